// File: doc/BRIEF.md
# SD Card Single-Line Block Writer

This block moves fixed-size data blocks from a sample FIFO onto an SD card over the one-bit SD bus. It uses only the command line and data line 0. It generates the card clock itself from the system clock. It waits until the FIFO reports that a whole block is buffered, the card is marked ready, and data line 0 is idle high. It then issues a single-block write command, waits for the card's response, and sends the block on data line 0. The block is framed with a start bit, the payload, a 16-bit CRC and an end bit. Last, the block reads back the card's CRC status token and waits out the card's busy period.

The command frame is assembled from three parts. The command index and the 7-bit command CRC come prebuilt from an external ROM, which is addressed by the current block number. The write address is the block number times the block size. The data CRC is computed serially while the payload is shifted out. A block counter advances after each block the card accepts. A rejected block parks the writer in an error state until reset.

Every action happens on card-clock bit boundaries:

- Outputs change when the card clock falls.
- The card's command and data-line inputs are registered when the card clock rises.

The FSM states and their transitions are:

- `ST_IDLE`: moves to `ST_CMD` when ready, block flag and an idle data line coincide.
- `ST_CMD`: after 48 bits, moves to `ST_RSP_WAIT`.
- `ST_RSP_WAIT`: moves to `ST_RSP` when a low command line is seen.
- `ST_RSP`: after the remaining 47 bits, moves to `ST_GAP`.
- `ST_GAP`: after `NWR` bits, moves to `ST_DSTART`.
- `ST_DSTART`: moves to `ST_DATA`.
- `ST_DATA`: after the last payload bit, moves to `ST_DCRC`.
- `ST_DCRC`: after 16 bits, moves to `ST_DEND`.
- `ST_DEND`: moves to `ST_TOK_WAIT`.
- `ST_TOK_WAIT`: moves to `ST_TOK` when a low data line is seen.
- `ST_TOK`: after three status bits and the end bit, moves to `ST_BUSY`.
- `ST_BUSY`: once the data line is high, moves to `ST_IDLE` if the token was good and to `ST_ERR` otherwise.
- `ST_ERR`: has no exit except reset.

Top module: `sd_block_writer`

## Requirements
- R1: A write command starts only at a falling card-clock edge where `card_ready`, `fifo_blk_rdy` and the registered data-line-0 sample are all high. Otherwise `cmd_oe` stays low.
- R2: The command frame is 48 bits, sent MSB first on the command line, in this order:
  - a 0 start bit;
  - a 1 direction bit;
  - the 6-bit index `rom_data[12:7]`;
  - a 32-bit argument equal to `blk_count * BLK_BYTES`;
  - the 7-bit CRC `rom_data[6:0]`;
  - a 1 end bit.
  
  `rom_addr` equals `blk_count`.
- R3: The writer waits for a 0 start bit on the command line and treats it and the following 47 bits as the response. The data line is then driven high for exactly `NWR` card clocks, followed by a single 0 start bit.
- R4: The payload is `BLK_BYTES` bytes taken in FIFO order, each sent MSB first. Exactly `BLK_BYTES` `fifo_rd` pulses are issued per block, and the head byte `fifo_rd_data` is taken when each pulse is issued.
- R5: After the payload come 16 CRC bits, MSB first, then a 1 end bit. The CRC uses polynomial x^16+x^12+x^5+1, starts from zero, and covers the payload bits in sending order.
- R6: The data line is released in the card clock after the end bit. After the card's 0 start bit, the next three bits form the status token, first bit most significant. The value 3'b010 accepts the block.
- R7: Any other token value drives `wr_error` high permanently. `blk_count` is left unchanged and no further command is started until reset.
- R8: While the card holds data line 0 low after the token, no command is driven and `blk_count` is unchanged. When the line returns high after an accepted token, `blk_count` increments by one.
- R9: `sd_clk` has a period of `2*HALF_DIV` clock cycles. The command and data-line outputs change only in the cycle after a falling `sd_clk` edge.
- R10: During reset:
  - `cmd_oe`, `d0_oe`, `fifo_rd`, `wr_error` and `blk_count` are zero;
  - `sd_clk` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| card_ready | input | 1 | Card has been initialised and may be written |
| fifo_blk_rdy | input | 1 | FIFO holds at least one whole block |
| fifo_rd_data | input | 8 | Head byte of the FIFO (first-word fall-through) |
| fifo_rd | output | 1 | One-cycle pop of the FIFO head |
| rom_addr | output | CNT_W | Command ROM address (current block number) |
| rom_data | input | 13 | Command index (bits 12:7) and its CRC7 (bits 6:0) |
| sd_clk | output | 1 | Card clock |
| cmd_out | output | 1 | Command line value when driven |
| cmd_oe | output | 1 | Command line drive enable |
| cmd_in | input | 1 | Command line as seen on the bus |
| d0_out | output | 1 | Data line 0 value when driven |
| d0_oe | output | 1 | Data line 0 drive enable |
| d0_in | input | 1 | Data line 0 as seen on the bus |
| blk_count | output | CNT_W | Number of blocks accepted by the card |
| wr_error | output | 1 | A block was rejected; writer halted |

## Verification
The bench plays the card bit by bit. It goes after several places where an off-by-one would show:

- **Response length and write gap.** A writer that miscounts the response or the gap starts data one clock early or late, and the measured gap differs from `NWR`.
- **Byte boundaries and the final pop.** Skipping or duplicating a FIFO pop shifts the payload or leaves the pop count off by one, and a CRC with the wrong seed or feedback fails the 16-bit compare.
- **Busy windows.** Busy windows of zero to six clocks catch a writer that leaves the busy state on the token's end bit or advances the counter early.
- **Rejected tokens and idle-line gating.** A rejected token must leave the counter alone and stop all further commands. A low data line, a missing ready or a missing block flag must each hold off the command.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_RSP_WAIT,
        ST_RSP,
        ST_GAP,
        ST_DSTART,
        ST_DATA,
        ST_DCRC,
        ST_DEND,
        ST_TOK_WAIT,
        ST_TOK,
        ST_BUSY,
        ST_ERR
    } sdw_state_e;

    localparam int          CMD_BITS  = 48;
    localparam int          RSP_BITS  = 48;
    localparam int          CRC_BITS  = 16;
    localparam int          ROM_W     = 13;
    localparam logic [2:0]  TOK_GOOD  = 3'b010;
    localparam logic [15:0] DATA_POLY = 16'h1021;

endpackage

// File: rtl/sdw_bitclk.sv
module sdw_bitclk #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic sd_clk,
    output logic rise_tk,
    output logic fall_tk
);
    localparam int PERIOD = 2 * HALF_DIV;
    localparam int CW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [CW-1:0] cnt;

    assign rise_tk = (cnt == CW'(HALF_DIV - 1));
    assign fall_tk = (cnt == CW'(PERIOD - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            sd_clk <= 1'b0;
        end else begin
            cnt <= fall_tk ? '0 : cnt + 1'b1;
            if (rise_tk) begin
                sd_clk <= 1'b1;
            end else if (fall_tk) begin
                sd_clk <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sdw_crc16.sv
module sdw_crc16 #(
    parameter logic [15:0] POLY = 16'h1021
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic upd,
    input  logic shft,
    input  logic din,
    output logic crc_msb
);
    logic [15:0] acc;

    assign crc_msb = acc[15];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (upd) begin
            acc <= {acc[14:0], 1'b0} ^ ((acc[15] ^ din) ? POLY : 16'h0000);
        end else if (shft) begin
            acc <= {acc[14:0], 1'b0};
        end
    end

endmodule

// File: rtl/sd_block_writer.sv
module sd_block_writer
    import sdw_pkg::*;
#(
    parameter int HALF_DIV  = 2,
    parameter int BLK_BYTES = 512,
    parameter int CNT_W     = 8,
    parameter int NWR       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             card_ready,
    input  logic             fifo_blk_rdy,
    input  logic [7:0]       fifo_rd_data,
    output logic             fifo_rd,
    output logic [CNT_W-1:0] rom_addr,
    input  logic [ROM_W-1:0] rom_data,
    output logic             sd_clk,
    output logic             cmd_out,
    output logic             cmd_oe,
    input  logic             cmd_in,
    output logic             d0_out,
    output logic             d0_oe,
    input  logic             d0_in,
    output logic [CNT_W-1:0] blk_count,
    output logic             wr_error
);
    localparam int DATA_BITS = BLK_BYTES * 8;
    localparam int BC_W      = $clog2(DATA_BITS) + 1;
    localparam int ADDR_SH   = $clog2(BLK_BYTES);

    sdw_state_e            state;
    logic [BC_W-1:0]       bitcnt;
    logic [CMD_BITS-1:0]   cmd_sh;
    logic [7:0]            dsh;
    logic [2:0]            tok;
    logic [CNT_W-1:0]      cnt_q;
    logic                  cmd_s, d0_s;
    logic                  rise_tk, fall_tk;
    logic                  crc_msb;
    logic [31:0]           wr_arg;
    logic [CMD_BITS-1:0]   frame;

    sdw_bitclk #(.HALF_DIV(HALF_DIV)) u_bitclk (
        .clk(clk), .rst_n(rst_n), .sd_clk(sd_clk),
        .rise_tk(rise_tk), .fall_tk(fall_tk)
    );

    sdw_crc16 #(.POLY(DATA_POLY)) u_crc (
        .clk(clk), .rst_n(rst_n),
        .clr (fall_tk && state == ST_DSTART),
        .upd (fall_tk && state == ST_DATA),
        .shft(fall_tk && state == ST_DCRC),
        .din (dsh[7]),
        .crc_msb(crc_msb)
    );

    assign wr_arg    = 32'(cnt_q) << ADDR_SH;
    assign frame     = {2'b01, rom_data[12:7], wr_arg, rom_data[6:0], 1'b1};
    assign rom_addr  = cnt_q;
    assign blk_count = cnt_q;
    assign wr_error  = (state == ST_ERR);

    // Bus inputs are registered at the rising card-clock edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_s <= 1'b1;
            d0_s  <= 1'b1;
        end else if (rise_tk) begin
            cmd_s <= cmd_in;
            d0_s  <= d0_in;
        end
    end

    // State register and datapath, advanced on falling card-clock edges.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bitcnt  <= '0;
            cmd_sh  <= '1;
            dsh     <= '0;
            tok     <= '0;
            cnt_q   <= '0;
            fifo_rd <= 1'b0;
        end else begin
            fifo_rd <= 1'b0;
            if (fall_tk) begin
                unique case (state)
                    ST_IDLE: begin
                        if (card_ready && fifo_blk_rdy && d0_s) begin
                            cmd_sh <= frame;
                            bitcnt <= '0;
                            state  <= ST_CMD;
                        end
                    end
                    ST_CMD: begin
                        if (bitcnt == BC_W'(CMD_BITS - 1)) begin
                            state <= ST_RSP_WAIT;
                        end else begin
                            cmd_sh <= {cmd_sh[CMD_BITS-2:0], 1'b0};
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                    ST_RSP_WAIT: begin
                        if (!cmd_s) begin
                            bitcnt <= '0;
                            state  <= ST_RSP;
                        end
                    end
                    ST_RSP: begin
                        if (bitcnt == BC_W'(RSP_BITS - 2)) begin
                            bitcnt <= '0;
                            state  <= ST_GAP;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                    ST_GAP: begin
                        if (bitcnt == BC_W'(NWR - 1)) begin
                            state <= ST_DSTART;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                    ST_DSTART: begin
                        dsh     <= fifo_rd_data;
                        fifo_rd <= 1'b1;
                        bitcnt  <= '0;
                        state   <= ST_DATA;
                    end
                    ST_DATA: begin
                        if (bitcnt == BC_W'(DATA_BITS - 1)) begin
                            bitcnt <= '0;
                            state  <= ST_DCRC;
                        end else begin
                            if (bitcnt[2:0] == 3'd7) begin
                                dsh     <= fifo_rd_data;
                                fifo_rd <= 1'b1;
                            end else begin
                                dsh <= {dsh[6:0], 1'b0};
                            end
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                    ST_DCRC: begin
                        if (bitcnt == BC_W'(CRC_BITS - 1)) begin
                            state <= ST_DEND;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                    ST_DEND: begin
                        state <= ST_TOK_WAIT;
                    end
                    ST_TOK_WAIT: begin
                        if (!d0_s) begin
                            bitcnt <= '0;
                            state  <= ST_TOK;
                        end
                    end
                    ST_TOK: begin
                        if (bitcnt == BC_W'(3)) begin
                            state <= ST_BUSY;
                        end else begin
                            tok    <= {tok[1:0], d0_s};
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                    ST_BUSY: begin
                        if (d0_s) begin
                            if (tok == TOK_GOOD) begin
                                cnt_q <= cnt_q + 1'b1;
                                state <= ST_IDLE;
                            end else begin
                                state <= ST_ERR;
                            end
                        end
                    end
                    ST_ERR: begin
                        state <= ST_ERR;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Output decode from the state register.
    always_comb begin
        cmd_out = cmd_sh[CMD_BITS-1];
        cmd_oe  = 1'b0;
        d0_oe   = 1'b0;
        d0_out  = 1'b1;
        unique case (state)
            ST_CMD:    cmd_oe = 1'b1;
            ST_GAP:    d0_oe  = 1'b1;
            ST_DSTART: begin d0_oe = 1'b1; d0_out = 1'b0;    end
            ST_DATA:   begin d0_oe = 1'b1; d0_out = dsh[7];  end
            ST_DCRC:   begin d0_oe = 1'b1; d0_out = crc_msb; end
            ST_DEND:   d0_oe  = 1'b1;
            default:   ;
        endcase
    end

    AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_oe) |-> ($past(card_ready) && $past(fifo_blk_rdy) && $past(d0_s))); // R1

    AST_POP_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> (state == ST_DATA)); // R4

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_error) |-> (wr_error && !cmd_oe)); // R7

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_count != $past(blk_count)) |->
            ($past(state) == ST_BUSY && $past(tok) == TOK_GOOD
             && blk_count == $past(blk_count) + 1'b1)); // R8

    AST_EDGE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fall_tk) |-> ($stable(cmd_oe) && $stable(cmd_out)
                             && $stable(d0_oe) && $stable(d0_out))); // R9

endmodule

// File: tb/sd_block_writer_tb.sv
module sd_block_writer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 1;
    localparam int BLK        = 512;
    localparam int CW         = 4;
    localparam int NWR_T      = 2;
    localparam int WD_CYCLES  = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          card_ready = 1'b0;
    logic          fifo_blk_rdy = 1'b0;
    logic [7:0]    fifo_rd_data;
    logic          fifo_rd;
    logic [CW-1:0] rom_addr;
    logic [12:0]   rom_data;
    logic          sd_clk, cmd_out, cmd_oe, d0_out, d0_oe;
    logic          cmd_line, d0_line;
    logic [CW-1:0] blk_count;
    logic          wr_error;
    logic          card_cmd_oe = 1'b0, card_cmd = 1'b1;
    logic          card_d0_oe = 1'b0, card_d0 = 1'b1;
    int            pops = 0;
    int            cyc = 0;
    int            checks = 0;
    int            failures = 0;
    bit            done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && fifo_rd) pops <= pops + 1;
    end

    function automatic logic [7:0] pat(input int b, input int i);
        return 8'((i * (2 * b + 1)) ^ (b * 37) ^ (i >> 8));
    endfunction

    function automatic logic [6:0] crc7(input logic [39:0] v);
        logic [6:0] c = '0;
        for (int k = 39; k >= 0; k--) begin
            logic fb = c[6] ^ v[k];
            c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
        end
        return c;
    endfunction

    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic bit_in);
        return {c[14:0], 1'b0} ^ ((c[15] ^ bit_in) ? 16'h1021 : 16'h0000);
    endfunction

    function automatic logic [47:0] exp_frame(input int b);
        logic [31:0] arg = 32'(b * BLK);
        return {2'b01, 6'd24, arg, crc7({2'b01, 6'd24, arg}), 1'b1};
    endfunction

    assign fifo_rd_data = pat(pops / BLK, pops % BLK);
    assign rom_data     = {6'd24, crc7({2'b01, 6'd24, 32'(rom_addr) << 9})};
    assign cmd_line     = cmd_oe ? cmd_out : (card_cmd_oe ? card_cmd : 1'b1);
    assign d0_line      = d0_oe ? d0_out : (card_d0_oe ? card_d0 : 1'b1);

    sd_block_writer #(.HALF_DIV(HALF), .BLK_BYTES(BLK), .CNT_W(CW), .NWR(NWR_T)) dut_i (
        .clk(clk), .rst_n(rst_n), .card_ready(card_ready), .fifo_blk_rdy(fifo_blk_rdy),
        .fifo_rd_data(fifo_rd_data), .fifo_rd(fifo_rd), .rom_addr(rom_addr),
        .rom_data(rom_data), .sd_clk(sd_clk), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
        .cmd_in(cmd_line), .d0_out(d0_out), .d0_oe(d0_oe), .d0_in(d0_line),
        .blk_count(blk_count), .wr_error(wr_error)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic rise();
        @(posedge sd_clk); #1;
    endtask

    task automatic fall();
        @(negedge sd_clk); #1;
    endtask

    task automatic watch_no_cmd(input int n, input string req, input string what);
        int seen = 0;
        for (int k = 0; k < n; k++) begin
            rise();
            if (cmd_oe) seen++;
        end
        check(seen == 0, req, what, seen, 0);
    endtask

    task automatic run_block(input int b, input int busy, input logic [2:0] token);
        logic [47:0] fr;
        logic [47:0] rsp;
        logic [15:0] c;
        logic [15:0] rc;
        logic [7:0]  byt;
        int gap, bad, hold;
        fifo_blk_rdy = 1'b1;
        do rise(); while (!(cmd_oe && !cmd_line));
        check(rom_addr == CW'(b), "R2", "rom address", rom_addr, b);
        fr[47] = 1'b0;
        for (int k = 46; k >= 0; k--) begin
            rise();
            fr[k] = cmd_line;
        end
        check(fr == exp_frame(b), "R2", "command frame", fr, exp_frame(b));
        fifo_blk_rdy = 1'b0;
        // R3: card answers after two idle clocks
        rsp = {2'b00, 6'd24, 32'h0000_0900, 7'h15, 1'b1};
        repeat (2) @(negedge sd_clk);
        for (int k = 47; k >= 0; k--) begin
            fall();
            card_cmd_oe = 1'b1;
            card_cmd    = rsp[k];
        end
        rise();
        check(!d0_oe, "R3", "data line idle during response", d0_oe, 0);
        fall();
        card_cmd_oe = 1'b0;
        gap = 0;
        while (1) begin
            rise();
            if (d0_oe && d0_line) gap++;
            else break;
        end
        check(gap == NWR_T && d0_oe && !d0_line, "R3", "high gap before start bit", gap, NWR_T);
        c = '0;
        bad = 0;
        for (int i = 0; i < BLK; i++) begin
            for (int j = 7; j >= 0; j--) begin
                rise();
                byt[j] = d0_line;
                if (!d0_oe) bad++;
                c = crc16_step(c, d0_line);
            end
            if (byt != pat(b, i)) bad++;
        end
        check(bad == 0, "R4", "payload bytes", bad, 0);
        for (int k = 15; k >= 0; k--) begin
            rise();
            rc[k] = d0_line;
        end
        check(rc == c, "R5", "data CRC16", rc, c);
        rise();
        check(d0_oe && d0_line, "R5", "end bit", {d0_oe, d0_line}, 2'b11);
        check(pops == BLK * (b + 1), "R4", "pop count", pops, BLK * (b + 1));
        fall();
        rise();
        check(!d0_oe, "R6", "data line released after end bit", d0_oe, 0);
        fall();
        card_d0_oe = 1'b1;
        card_d0    = 1'b0;
        for (int k = 2; k >= 0; k--) begin
            fall();
            card_d0 = token[k];
        end
        fall();
        card_d0 = 1'b1;
        hold = 0;
        for (int n = 0; n < busy; n++) begin
            fall();
            card_d0 = 1'b0;
            rise();
            if (cmd_oe || blk_count != CW'(b)) hold++;
        end
        if (busy > 0) check(hold == 0, "R8", "quiet and count held while busy", hold, 0);
        fall();
        card_d0_oe = 1'b0;
        repeat (4) rise();
        if (token == 3'b010) begin
            check(blk_count == CW'(b + 1) && !wr_error, "R8", "count after accepted block",
                  blk_count, b + 1);
        end else begin
            check(blk_count == CW'(b) && wr_error, "R7", "rejected block: count and error",
                  {wr_error, blk_count}, {1'b1, 4'(b)});
        end
    endtask

    initial begin
        int t0, t1;
        repeat (5) @(posedge clk);
        #1;
        // R10 reset state
        check(!cmd_oe && !d0_oe && !fifo_rd, "R10", "drivers off in reset",
              {cmd_oe, d0_oe, fifo_rd}, 0);
        check(blk_count == '0 && !wr_error && !sd_clk, "R10", "count, error, clock in reset",
              {sd_clk, wr_error, blk_count}, 0);
        rst_n = 1'b1;
        // R9 card clock period
        @(posedge sd_clk); t0 = cyc;
        @(posedge sd_clk); t1 = cyc;
        check(t1 - t0 == 2 * HALF, "R9", "card clock period", t1 - t0, 2 * HALF);
        // R1 hold-off sweeps
        card_ready = 1'b0; fifo_blk_rdy = 1'b1;
        watch_no_cmd(30, "R1", "no command without card_ready");
        card_ready = 1'b1; fifo_blk_rdy = 1'b0;
        watch_no_cmd(30, "R1", "no command without block flag");
        fall();
        card_d0_oe = 1'b1; card_d0 = 1'b0;
        repeat (3) rise();
        fifo_blk_rdy = 1'b1;
        watch_no_cmd(30, "R1", "no command while data line low");
        fall();
        card_d0_oe = 1'b0;
        // accepted blocks with a sweep of busy lengths
        run_block(0, 0, 3'b010);
        run_block(1, 1, 3'b010);
        run_block(2, 3, 3'b010);
        run_block(3, 6, 3'b010);
        // rejected block: R7
        run_block(4, 2, 3'b101);
        fifo_blk_rdy = 1'b1;
        watch_no_cmd(60, "R7", "no command after rejection");
        check(wr_error && blk_count == CW'(4), "R7", "error held",
              {wr_error, blk_count}, {1'b1, 4'd4});
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule